// File: doc/BRIEF.md
# Learned-Address Table with Command Registers

This block holds a small table of Ethernet station entries for a switch. Each entry has a MAC address, a VLAN ID, a destination port mask, a priority and a status code. Software reaches the table through four 32-bit registers: three data words that hold one entry, and a function word that holds the command. Software fills the data words, writes an operation code with the busy bit set, and polls until busy reads back as zero. Any result is then in the data words.

The operations are no-op, flush, load, search and get-next. An entry is found by its MAC address together with its VLAN ID. Get-next uses the entry currently in the data words as a cursor. It returns the next valid entry in ascending slot order. When the walk has run out of entries, it clears all three data words to zero, so the next get-next starts the walk again from the beginning. Flush empties the table one slot per clock. Every other command finishes in a single clock.

Top module: `mac_tbl_ctrl`

## Requirements
- R1: Register index 0 is data word A, index 1 is data word B, index 2 is data word C and index 3 is the function word.
  - Word A holds MAC bytes 0..3, with byte 0 in bits 31:24 down to byte 3 in bits 7:0.
  - Word B holds MAC byte 4 in bits 7:0, MAC byte 5 in bits 15:8, the port mask in bits 22:16 and the priority in bits 26:24.
  - Word C holds the status in bits 3:0 and the VLAN ID in bits 19:8.
  - The function word holds the opcode in bits 3:0, a port number in bits 11:8, the full flag in bit 12 (read-only) and busy in bit 31.
  - All other bits read as zero, and every register reads zero after reset.
- R2: Writing the function word with bit 31 set starts the programmed opcode. Busy reads 1 from the next clock. A non-flush command clears busy after exactly one busy cycle.
- R3: While busy is set, writes to any register are ignored. This includes the data words and the opcode.
- R4: Load (opcode 2) writes the data words into the valid slot whose MAC and VLAN match. If there is no such slot, it writes them into the lowest-index slot whose status is zero. A load with status zero onto a matching slot removes that entry.
- R5: A load that finds no matching slot and no free slot sets the full flag and leaves the table unchanged. The flag clears when the next command starts.
- R6: Search (opcode 7) copies the valid entry whose MAC and VLAN match the data words into the data words. When there is no match, it clears all three words to zero.
- R7: Get-next (opcode 6) with a cursor whose MAC and VLAN are both zero returns the valid entry in the lowest-index slot.
- R8: Get-next with a cursor that names a valid entry returns the next valid entry at a higher slot index. When none is left, it clears all three words to zero. Removed slots are skipped.
- R9: Flush (opcode 1) clears the status of every slot. Busy stays set for exactly DEPTH cycles, and the data words are unchanged.
- R10: No-op (opcode 0) and undefined opcodes change neither the table nor the data words, and they finish in one busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register index for the write |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Register index for the read |
| reg_rdata | output | 32 | Read data (combinational) |

## Verification
The checker assumes that the write strobe and write index are never unknown after reset. It also assumes that an opcode is held from the clock that sets busy until busy clears, which the block ensures by dropping writes while busy. The bench drives every input on the falling edge, only through the register interface, and polls busy before each new command. The one exception is the directed case that writes on purpose during a flush, to show that those writes are dropped. The walk, search and full-table cases observe the table only through the data words after get-next and search commands.

// File: rtl/mac_tbl_pkg.sv
package mac_tbl_pkg;
  localparam int MAC_W  = 48;
  localparam int VID_W  = 12;
  localparam int PORT_W = 7;
  localparam int PRI_W  = 3;
  localparam int STAT_W = 4;

  typedef struct packed {
    logic [MAC_W-1:0]  mac;
    logic [VID_W-1:0]  vid;
    logic [PORT_W-1:0] ports;
    logic [PRI_W-1:0]  prio;
    logic [STAT_W-1:0] stat;
  } tbl_ent_t;

  localparam logic [3:0] CMD_NOP   = 4'd0;
  localparam logic [3:0] CMD_FLUSH = 4'd1;
  localparam logic [3:0] CMD_LOAD  = 4'd2;
  localparam logic [3:0] CMD_NEXT  = 4'd6;
  localparam logic [3:0] CMD_FIND  = 4'd7;

  localparam logic [1:0] RIX_A  = 2'd0;
  localparam logic [1:0] RIX_B  = 2'd1;
  localparam logic [1:0] RIX_C  = 2'd2;
  localparam logic [1:0] RIX_FN = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_SWEEP} ctl_st_e;
endpackage

// File: rtl/mac_tbl_store.sv
module mac_tbl_store
  import mac_tbl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  tbl_ent_t              wr_ent,
  input  logic                  clr_en,
  input  logic [IDX_W-1:0]      clr_idx,
  output tbl_ent_t [DEPTH-1:0]  ents
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    tbl_ent_t slot_q;
    logic     hit_wr;
    logic     hit_clr;

    assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(g));
    assign hit_clr = clr_en && (clr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (hit_wr) begin
        slot_q <= wr_ent;
      end else if (hit_clr) begin
        slot_q.stat <= '0;
      end
    end

    assign ents[g] = slot_q;
  end
endmodule

// File: rtl/mac_tbl_scan.sv
module mac_tbl_scan
  import mac_tbl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  tbl_ent_t [DEPTH-1:0]  ents,
  input  logic [MAC_W-1:0]      key_mac,
  input  logic [VID_W-1:0]      key_vid,
  input  logic                  from_start,
  output logic                  match_hit,
  output logic [IDX_W-1:0]      match_idx,
  output logic                  free_hit,
  output logic [IDX_W-1:0]      free_idx,
  output logic                  next_hit,
  output logic [IDX_W-1:0]      next_idx
);
  logic [DEPTH-1:0] live;
  logic [DEPTH-1:0] same;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign live[g] = (ents[g].stat != '0);
    assign same[g] = live[g] && (ents[g].mac == key_mac) && (ents[g].vid == key_vid);
  end

  // Lowest index wins: walk downward so the last assignment is the smallest.
  always_comb begin
    match_hit = 1'b0;
    match_idx = '0;
    free_hit  = 1'b0;
    free_idx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (same[i]) begin
        match_hit = 1'b1;
        match_idx = IDX_W'(i);
      end
      if (!live[i]) begin
        free_hit = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    next_hit = 1'b0;
    next_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (live[i] && (from_start || (match_hit && (IDX_W'(i) > match_idx)))) begin
        next_hit = 1'b1;
        next_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mac_tbl_ctrl.sv
module mac_tbl_ctrl
  import mac_tbl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic [1:0]  reg_raddr,
  output logic [31:0] reg_rdata
);
  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q;
  logic rst_ok_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ok_q   <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ok_q   <= rst_meta_q;
    end
  end

  ctl_st_e    st_q, st_d;
  tbl_ent_t   cur_q, cur_d;
  logic       cur_ld;
  logic [3:0] op_q, op_d;
  logic [3:0] pnum_q, pnum_d;
  logic       fn_ld;
  logic       full_q, full_d;
  logic [IDX_W-1:0] sweep_q, sweep_d;

  tbl_ent_t [DEPTH-1:0] ents;
  logic             t_wr;
  logic [IDX_W-1:0] t_widx;
  logic             t_clr;
  logic             m_hit, f_hit, n_hit;
  logic [IDX_W-1:0] m_idx, f_idx, n_idx;
  logic             cur_zero;
  logic             busy;

  assign busy     = (st_q != ST_IDLE);
  assign cur_zero = (cur_q.mac == '0) && (cur_q.vid == '0);

  mac_tbl_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_ok_q),
    .wr_en   (t_wr),
    .wr_idx  (t_widx),
    .wr_ent  (cur_q),
    .clr_en  (t_clr),
    .clr_idx (sweep_q),
    .ents    (ents)
  );

  mac_tbl_scan #(.DEPTH(DEPTH)) u_scan (
    .ents       (ents),
    .key_mac    (cur_q.mac),
    .key_vid    (cur_q.vid),
    .from_start (cur_zero),
    .match_hit  (m_hit),
    .match_idx  (m_idx),
    .free_hit   (f_hit),
    .free_idx   (f_idx),
    .next_hit   (n_hit),
    .next_idx   (n_idx)
  );

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    cur_ld  = 1'b0;
    op_d    = op_q;
    pnum_d  = pnum_q;
    fn_ld   = 1'b0;
    full_d  = full_q;
    sweep_d = sweep_q;
    t_wr    = 1'b0;
    t_widx  = '0;
    t_clr   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (reg_wr) begin
          unique case (reg_waddr)
            RIX_A: begin
              cur_d.mac[47:16] = reg_wdata;
              cur_ld = 1'b1;
            end
            RIX_B: begin
              cur_d.mac[15:8] = reg_wdata[7:0];
              cur_d.mac[7:0]  = reg_wdata[15:8];
              cur_d.ports     = reg_wdata[22:16];
              cur_d.prio      = reg_wdata[26:24];
              cur_ld = 1'b1;
            end
            RIX_C: begin
              cur_d.stat = reg_wdata[3:0];
              cur_d.vid  = reg_wdata[19:8];
              cur_ld = 1'b1;
            end
            default: begin
              op_d   = reg_wdata[3:0];
              pnum_d = reg_wdata[11:8];
              fn_ld  = 1'b1;
              if (reg_wdata[31]) begin
                full_d  = 1'b0;
                sweep_d = '0;
                st_d    = (reg_wdata[3:0] == CMD_FLUSH) ? ST_SWEEP : ST_RUN;
              end
            end
          endcase
        end
      end
      ST_RUN: begin
        st_d = ST_IDLE;
        unique case (op_q)
          CMD_LOAD: begin
            if (m_hit) begin
              t_wr   = 1'b1;
              t_widx = m_idx;
            end else if (f_hit) begin
              t_wr   = 1'b1;
              t_widx = f_idx;
            end else begin
              full_d = 1'b1;
            end
          end
          CMD_FIND: begin
            cur_d  = m_hit ? ents[m_idx] : '0;
            cur_ld = 1'b1;
          end
          CMD_NEXT: begin
            cur_d  = n_hit ? ents[n_idx] : '0;
            cur_ld = 1'b1;
          end
          default: ;
        endcase
      end
      ST_SWEEP: begin
        t_clr = 1'b1;
        if (sweep_q == IDX_W'(DEPTH - 1)) begin
          st_d = ST_IDLE;
        end else begin
          sweep_d = sweep_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ok_q) begin
    if (!rst_ok_q) begin
      st_q    <= ST_IDLE;
      full_q  <= 1'b0;
      sweep_q <= '0;
    end else begin
      st_q    <= st_d;
      full_q  <= full_d;
      sweep_q <= sweep_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ok_q) begin
    if (!rst_ok_q) begin
      cur_q <= '0;
    end else if (cur_ld) begin
      cur_q <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ok_q) begin
    if (!rst_ok_q) begin
      op_q   <= '0;
      pnum_q <= '0;
    end else if (fn_ld) begin
      op_q   <= op_d;
      pnum_q <= pnum_d;
    end
  end

  // Read mux
  always_comb begin
    unique case (reg_raddr)
      RIX_A:   reg_rdata = cur_q.mac[47:16];
      RIX_B:   reg_rdata = {5'b0, cur_q.prio, 1'b0, cur_q.ports, cur_q.mac[7:0], cur_q.mac[15:8]};
      RIX_C:   reg_rdata = {12'b0, cur_q.vid, 4'b0, cur_q.stat};
      default: reg_rdata = {busy, 18'b0, full_q, pnum_q, 4'b0, op_q};
    endcase
  end
endmodule

// File: rtl/mac_tbl_chk.sv
module mac_tbl_chk
  import mac_tbl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 2
) (
  input logic       clk,
  input logic       rst_ok,
  input ctl_st_e    st,
  input tbl_ent_t   cur,
  input logic [3:0] op,
  input logic       full
);
  logic       busy_c;
  logic       run_c;
  logic       sweep_c;
  logic [CW-1:0] sw_cnt;

  assign busy_c  = (st != ST_IDLE);
  assign run_c   = (st == ST_RUN);
  assign sweep_c = (st == ST_SWEEP);

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      sw_cnt <= '0;
    end else if (sweep_c) begin
      sw_cnt <= sw_cnt + 1'b1;
    end else begin
      sw_cnt <= '0;
    end
  end

  AST_RUN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ok)
    run_c |=> !busy_c);                                         // R2
  AST_SWEEP_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_ok)
    sweep_c |=> $stable(cur));                                  // R3
  AST_BUSY_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_ok)
    busy_c |=> $stable(op));                                    // R3
  AST_FULL_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(full) |-> ($past(run_c) && $past(op) == CMD_LOAD));   // R5
  AST_START_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(busy_c) |-> !full);                                   // R5
  AST_WALK_END_CLEAN: assert property (@(posedge clk) disable iff (!rst_ok)
    (run_c && op == CMD_NEXT) |=> (cur.stat != '0 || (cur.mac == '0 && cur.vid == '0))); // R8
  AST_SWEEP_BOUND: assert property (@(posedge clk) disable iff (!rst_ok)
    sweep_c |-> (sw_cnt < CW'(DEPTH)));                         // R9
endmodule

bind mac_tbl_ctrl mac_tbl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk    (clk),
  .rst_ok (rst_ok_q),
  .st     (st_q),
  .cur    (cur_q),
  .op     (op_q),
  .full   (full_q)
);

// File: tb/mac_tbl_ctrl_tb.sv
`timescale 1ns/1ps
module mac_tbl_ctrl_tb;
  localparam int DEPTH = 16;

  typedef struct packed {
    logic [47:0] mac;
    logic [11:0] vid;
    logic [6:0]  ports;
    logic [2:0]  prio;
    logic [3:0]  stat;
  } vec_t;

  localparam vec_t VECS [0:4] = '{
    '{48'h02_11_22_33_44_55, 12'h001, 7'h03, 3'd1, 4'hF},
    '{48'h02_AA_BB_CC_DD_EE, 12'h00A, 7'h10, 3'd5, 4'h7},
    '{48'h00_00_00_00_00_01, 12'h000, 7'h7F, 3'd7, 4'h1},
    '{48'hFF_FF_FF_FF_FF_FF, 12'hFFF, 7'h40, 3'd0, 4'h2},
    '{48'h02_11_22_33_44_55, 12'h002, 7'h01, 3'd3, 4'h3}
  };

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_waddr;
  logic [31:0] reg_wdata;
  logic [1:0]  reg_raddr;
  logic [31:0] reg_rdata;
  int n_chk;
  int n_bad;

  mac_tbl_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] pk_a(vec_t v);
    return v.mac[47:16];
  endfunction
  function automatic logic [31:0] pk_b(vec_t v);
    return {5'b0, v.prio, 1'b0, v.ports, v.mac[7:0], v.mac[15:8]};
  endfunction
  function automatic logic [31:0] pk_c(vec_t v);
    return {12'b0, v.vid, 4'b0, v.stat};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [31:0] d);
    reg_raddr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic issue(logic [3:0] op, output int cyc);
    logic [31:0] f;
    wr_reg(2'd3, {1'b1, 27'b0, op});
    cyc = 0;
    rd_reg(2'd3, f);
    while (f[31] && cyc < 100) begin
      cyc++;
      @(negedge clk);
      rd_reg(2'd3, f);
    end
  endtask

  task automatic put_ent(vec_t v);
    wr_reg(2'd0, pk_a(v));
    wr_reg(2'd1, pk_b(v));
    wr_reg(2'd2, pk_c(v));
  endtask

  task automatic load_ent(vec_t v);
    int c;
    put_ent(v);
    issue(4'd2, c);
  endtask

  task automatic find_key(vec_t v);
    int c;
    wr_reg(2'd0, pk_a(v));
    wr_reg(2'd1, {16'b0, v.mac[7:0], v.mac[15:8]});
    wr_reg(2'd2, {12'b0, v.vid, 8'b0});
    issue(4'd7, c);
  endtask

  task automatic expect_ent(string tag, vec_t v);
    logic [31:0] d;
    rd_reg(2'd0, d); chk(tag, d, pk_a(v));
    rd_reg(2'd1, d); chk(tag, d, pk_b(v));
    rd_reg(2'd2, d); chk(tag, d, pk_c(v));
  endtask

  task automatic zero_cursor();
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd1, 32'h0);
    wr_reg(2'd2, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c;
    vec_t nv;
    vec_t zv;
    n_chk = 0; n_bad = 0;
    zv = '0;
    reg_wr = 1'b0; reg_waddr = 2'd0; reg_wdata = 32'h0; reg_raddr = 2'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), d); chk("R1 reset", d, 32'h0);
    end

    // R1 field masking and readback
    wr_reg(2'd0, 32'hFFFF_FFFF);
    wr_reg(2'd1, 32'hFFFF_FFFF);
    wr_reg(2'd2, 32'hFFFF_FFFF);
    wr_reg(2'd3, 32'h7FFF_FFF5);
    rd_reg(2'd0, d); chk("R1 word A", d, 32'hFFFF_FFFF);
    rd_reg(2'd1, d); chk("R1 word B", d, 32'h077F_FFFF);
    rd_reg(2'd2, d); chk("R1 word C", d, 32'h000F_FF0F);
    rd_reg(2'd3, d); chk("R1 function", d, 32'h0000_0F05);

    // R2 R10 no-op and undefined opcode
    issue(4'd0, c); chk("R2 nop busy cycles", 32'(c), 32'd1);
    rd_reg(2'd1, d); chk("R10 nop keeps data", d, 32'h077F_FFFF);
    issue(4'hA, c); chk("R10 undefined busy cycles", 32'(c), 32'd1);
    rd_reg(2'd2, d); chk("R10 undefined keeps data", d, 32'h000F_FF0F);

    // R4 R6 vector loop: load then search each
    foreach (VECS[i]) begin
      put_ent(VECS[i]);
      issue(4'd2, c);
      chk("R2 load busy cycles", 32'(c), 32'd1);
      rd_reg(2'd3, d); chk("R5 load no full", d, 32'h0000_0002);
      find_key(VECS[i]);
      expect_ent("R6 search hit", VECS[i]);
    end

    // R7 R8 walk in slot order
    zero_cursor();
    for (int i = 0; i < 5; i++) begin
      issue(4'd6, c);
      expect_ent(i == 0 ? "R7 walk first" : "R8 walk next", VECS[i]);
    end
    issue(4'd6, c);
    expect_ent("R8 walk end", zv);

    // R4 remove slot 2, walk skips it
    nv = VECS[2]; nv.stat = 4'h0;
    load_ent(nv);
    zero_cursor();
    issue(4'd6, c); expect_ent("R8 skip walk 0", VECS[0]);
    issue(4'd6, c); expect_ent("R8 skip walk 1", VECS[1]);
    issue(4'd6, c); expect_ent("R8 skip walk 3", VECS[3]);

    // R4 new entry fills the lowest free slot (slot 2)
    nv = '{48'h0A_0B_0C_0D_0E_0F, 12'h005, 7'h22, 3'd2, 4'h9};
    load_ent(nv);
    zero_cursor();
    issue(4'd6, c); issue(4'd6, c); issue(4'd6, c);
    expect_ent("R4 first free slot", nv);

    // R4 overwrite on matching key
    nv = VECS[1]; nv.ports = 7'h2A;
    load_ent(nv);
    find_key(VECS[1]);
    expect_ent("R4 overwrite", nv);

    // R6 search miss
    nv = '{48'hDE_AD_00_00_BE_EF, 12'h001, 7'h0, 3'd0, 4'h0};
    find_key(nv);
    expect_ent("R6 search miss", zv);

    // R9 flush length
    issue(4'd1, c); chk("R9 flush busy cycles", 32'(c), DEPTH);

    // R3 writes during busy are dropped
    wr_reg(2'd0, 32'h1111_1111);
    wr_reg(2'd3, 32'h8000_0001);
    wr_reg(2'd0, 32'h2222_2222);
    wr_reg(2'd3, 32'h8000_0007);
    repeat (DEPTH + 2) @(negedge clk);
    rd_reg(2'd0, d); chk("R3 data write ignored", d, 32'h1111_1111);
    rd_reg(2'd3, d); chk("R3 function write ignored", d, 32'h0000_0001);
    rd_reg(2'd1, d); chk("R9 flush keeps data", d, 32'h0);

    // R9 table empty after flush
    zero_cursor();
    issue(4'd6, c);
    rd_reg(2'd2, d); chk("R9 flushed walk ends", d, 32'h0);

    // R5 fill every slot, then overflow
    for (int i = 0; i < DEPTH; i++) begin
      nv = '{{40'h0A_00_00_00_00, 8'(i + 1)}, 12'h001, 7'h01, 3'd0, 4'h1};
      load_ent(nv);
    end
    rd_reg(2'd3, d); chk("R5 table just full", d, 32'h0000_0002);
    nv = '{48'h0A_00_00_00_00_99, 12'h001, 7'h01, 3'd0, 4'h1};
    load_ent(nv);
    rd_reg(2'd3, d); chk("R5 full flag", d, 32'h0000_1002);
    find_key(nv);
    expect_ent("R5 overflow not stored", zv);
    issue(4'd0, c);
    rd_reg(2'd3, d); chk("R5 flag cleared", d, 32'h0000_0000);
    nv = '{{40'h0A_00_00_00_00, 8'(DEPTH)}, 12'h001, 7'h01, 3'd0, 4'h1};
    find_key(nv);
    expect_ent("R5 last slot kept", nv);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule